// File: doc/BRIEF.md
# GPIO Port with Per-Condition Interrupt Tracking

This block is a memory-mapped general-purpose I/O port of up to 32 pins. It sits on a simple word-wide register bus. Each pin has storage for a sense (input) enable, a drive (output) enable, a drive value, a pull-up enable, a drive-strength bit, an output polarity bit and two alternate-function storage bits. The pad side sees the drive value after the polarity inversion, plus the drive enable, pull-up and strength controls. Incoming pad levels pass through a two-stage synchronizer and are gated by the sense enable before anything else looks at them.

Four interrupt conditions are tracked separately for every pin: a rising edge, a falling edge, a high level and a low level. Each condition has its own flag register and its own mask register. A flag latches whenever its condition occurs, whatever its mask holds. Software clears flags by writing ones. Level flags latch again at once while their level persists. Each pin drives a separate interrupt line, so an upstream interrupt controller can tell the pins apart without decoding anything.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted every register reads zero, the pad drive enable, pad value, pull-up, strength and alternate-function outputs are zero, and no interrupt line is active.
- R2: Registers are 32-bit words at byte offsets 0x00 (synchronized input, read-only) and then, every 4 bytes: sense enable 0x04, drive enable 0x08, drive value 0x0C, pull-up 0x10, strength 0x14, rise mask 0x18, rise flag 0x1C, fall mask 0x20, fall flag 0x24, high mask 0x28, high flag 0x2C, low mask 0x30, low flag 0x34, alternate enable 0x38, alternate select 0x3C, polarity 0x40. Bit n refers to pin n. Writable storage registers read back what was written. Writes to 0x00 are ignored. Offsets above 0x40 read zero.
- R3: The pad value equals drive value XOR polarity. The pad drive enable equals the drive-enable register. The pull-up, strength and alternate-function outputs mirror their registers. The drive value can be written while the drive enable is 0, and turning the driver on afterwards does not change the pad value.
- R4: The input register returns the pad level after two clock edges of synchronization, ANDed with the sense enable.
- R5: A 0-to-1 change of the synchronized, enabled input of pin n sets bit n of both the rise flag and the high flag. A 1-to-0 change sets bit n of both the fall flag and the low flag.
- R6: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. Other bits are not disturbed.
- R7: A level flag whose level still holds is set again the cycle after a clear. When a set and a clear hit the same cycle, the set wins.
- R8: Flags latch their condition even when the matching mask bit is 0.
- R9: Interrupt line n is the OR, over the four conditions, of flag bit n AND mask bit n.
- R10: A pin whose sense enable is 0 reads as low, so clearing its sense enable while its pad is high produces a falling edge and a persistent low condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Pad output value after polarity |
| pad_oe | output | NPINS | Pad driver enable |
| pad_pullup | output | NPINS | Pull-up enable |
| pad_strength | output | NPINS | Drive strength select |
| alt_en | output | NPINS | Alternate-function enable storage |
| alt_sel | output | NPINS | Alternate-function select storage |
| irq | output | NPINS | One interrupt line per pin |

## Verification
The hardest case to reach from the ports is a clear that collides with a condition that still holds. To be meaningful, the clear must land only after the two synchronizer stages and the previous-value register have settled on a stable pad level. Otherwise it is ambiguous whether an edge or a level set the flag. The stimulus therefore holds each pad pattern for several cycles, clears all four flag registers, and only then applies the next random pattern. The expected flags are then exactly the stale levels of the old pattern, plus the edges and levels of the new one. Directed steps cover clearing one level flag while its level holds, clearing a single bit beside others, writing zero, and withdrawing the sense enable under a high pad.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_COND = 4;
  localparam int NUM_REGS = 17;

  // word indices; offsets are index*4
  localparam int R_IN      = 0;
  localparam int R_SENSE   = 1;
  localparam int R_DRVEN   = 2;
  localparam int R_DRVVAL  = 3;
  localparam int R_PULL    = 4;
  localparam int R_STR     = 5;
  localparam int R_RISE_M  = 6;
  localparam int R_RISE_F  = 7;
  localparam int R_FALL_M  = 8;
  localparam int R_FALL_F  = 9;
  localparam int R_HI_M    = 10;
  localparam int R_HI_F    = 11;
  localparam int R_LO_M    = 12;
  localparam int R_LO_F    = 13;
  localparam int R_ALT_EN  = 14;
  localparam int R_ALT_SEL = 15;
  localparam int R_POL     = 16;

  // condition order: mask at R_RISE_M + 2*c, flag one word above
  localparam int C_RISE = 0;
  localparam int C_FALL = 1;
  localparam int C_HIGH = 2;
  localparam int C_LOW  = 3;

  function automatic bit is_storage(int idx);
    return !(idx == R_IN || idx == R_RISE_F || idx == R_FALL_F ||
             idx == R_HI_F || idx == R_LO_F);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] sense_en,
  output logic [NPINS-1:0] in_val,
  output logic [NPINS-1:0] prev_val
);
  logic [NPINS-1:0] meta_q, sync_q, prev_q;
  logic [NPINS-1:0] gated_w;

  always_comb gated_w = sync_q & sense_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= gated_w;
    end
  end

  assign in_val   = gated_w;
  assign prev_val = prev_q;
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_vec,
  input  logic [NPINS-1:0] clr_vec,
  output logic [NPINS-1:0] flag_q
);
  logic [NPINS-1:0] flag_d;

  // a set in the same cycle as a clear wins
  always_comb flag_d = (flag_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pullup,
  output logic [NPINS-1:0]  pad_strength,
  output logic [NPINS-1:0]  alt_en,
  output logic [NPINS-1:0]  alt_sel,
  output logic [NPINS-1:0]  irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    word_idx;
  logic                addr_ok;
  logic [NPINS-1:0]    wdata_p;
  logic [NUM_REGS-1:0] wr_hit;

  logic [NPINS-1:0] store_q [NUM_REGS];
  logic [NPINS-1:0] store_d [NUM_REGS];

  logic [NPINS-1:0] in_val, prev_val;
  logic [NUM_COND-1:0][NPINS-1:0] set_vec, clr_vec, flag_q;
  logic [NPINS-1:0] rdata_w, irq_w;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign addr_ok  = (bus_addr[1:0] == 2'b00);
  assign wdata_p  = bus_wdata[NPINS-1:0];

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++)
      wr_hit[r] = bus_sel && bus_we && addr_ok && (int'(word_idx) == r);
  end

  // storage registers: next state
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++)
      store_d[r] = (wr_hit[r] && is_storage(r)) ? wdata_p : store_q[r];
  end

  // storage registers: state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) store_q[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) store_q[r] <= store_d[r];
    end
  end

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .sense_en (store_q[R_SENSE]),
    .in_val   (in_val),
    .prev_val (prev_val)
  );

  for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
    always_comb begin
      case (c)
        C_RISE:  set_vec[c] =  in_val & ~prev_val;
        C_FALL:  set_vec[c] = ~in_val &  prev_val;
        C_HIGH:  set_vec[c] =  in_val;
        default: set_vec[c] = ~in_val;
      endcase
      clr_vec[c] = wr_hit[R_RISE_F + 2*c] ? wdata_p : '0;
    end

    gpio_flag_bank #(.NPINS(NPINS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec[c]),
      .clr_vec (clr_vec[c]),
      .flag_q  (flag_q[c])
    );
  end

  always_comb begin
    irq_w = '0;
    for (int c = 0; c < NUM_COND; c++)
      irq_w = irq_w | (flag_q[c] & store_q[R_RISE_M + 2*c]);
  end

  always_comb begin
    rdata_w = '0;
    if (addr_ok && int'(word_idx) < NUM_REGS) begin
      case (int'(word_idx))
        R_IN:     rdata_w = in_val;
        R_RISE_F: rdata_w = flag_q[C_RISE];
        R_FALL_F: rdata_w = flag_q[C_FALL];
        R_HI_F:   rdata_w = flag_q[C_HIGH];
        R_LO_F:   rdata_w = flag_q[C_LOW];
        default:  rdata_w = store_q[word_idx];
      endcase
    end
  end

  assign bus_rdata    = DATA_W'(rdata_w);
  assign pad_out      = store_q[R_DRVVAL] ^ store_q[R_POL];
  assign pad_oe       = store_q[R_DRVEN];
  assign pad_pullup   = store_q[R_PULL];
  assign pad_strength = store_q[R_STR];
  assign alt_en       = store_q[R_ALT_EN];
  assign alt_sel      = store_q[R_ALT_SEL];
  assign irq          = irq_w;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NPINS-1:0]  in_val,
  input logic [NPINS-1:0]  prev_val,
  input logic [NPINS-1:0]  rise_q,
  input logic [NPINS-1:0]  fall_q,
  input logic [NPINS-1:0]  high_q,
  input logic [NPINS-1:0]  low_q,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe
);
  logic armed_q;
  logic wr_rise, wr_fall_zero, any_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign any_wr       = bus_sel && bus_we;
  assign wr_rise      = any_wr && (int'(bus_addr) == 4*R_RISE_F);
  assign wr_fall_zero = any_wr && (int'(bus_addr) == 4*R_FALL_F) &&
                        (bus_wdata[NPINS-1:0] == '0);

  // R5: a newly set rise bit needs a 0-to-1 step of the delayed input
  p_rise_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_q & ~$past(rise_q)) & ~(prev_val & ~$past(prev_val))) == '0);

  // R7: the high flag always covers the level seen on the previous edge
  p_high_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> ((prev_val & ~high_q) == '0));

  // R7: same for the low condition
  p_low_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> ((~prev_val & ~low_q) == '0));

  // R6: a written one clears the rise bit unless an edge arrives with it
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> ((rise_q & $past(bus_wdata[NPINS-1:0]) &
                  ~$past(in_val & ~prev_val)) == '0));

  // R6: writing zero to a flag register removes nothing
  p_zero_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall_zero |=> (($past(fall_q) & ~fall_q) == '0));

  // R3: pad drive only moves after a register write
  p_pad_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .in_val    (in_val),
  .prev_val  (prev_val),
  .rise_q    (flag_q[0]),
  .fall_q    (flag_q[1]),
  .high_q    (flag_q[2]),
  .low_q     (flag_q[3]),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  localparam int NP = 32;
  localparam int AW = 7;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  // word indices used by the bench (offset = index*4)
  localparam int I_IN = 0, I_SENSE = 1, I_DRVEN = 2, I_DRVVAL = 3, I_PULL = 4,
                 I_STR = 5, I_RM = 6, I_RF = 7, I_FM = 8, I_FF = 9, I_HM = 10,
                 I_HF = 11, I_LM = 12, I_LF = 13, I_AEN = 14, I_ASEL = 15, I_POL = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe, pad_pullup, pad_strength, alt_en, alt_sel, irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [17];

  always #4 clk = ~clk;

  gpio_irq_port #(.NPINS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pullup(pad_pullup), .pad_strength(pad_strength),
    .alt_en(alt_en), .alt_sel(alt_sel), .irq(irq)
  );

  function automatic logic [31:0] exp_irq(logic [31:0] r, f, h, l, mr, mf, mh, ml);
    return (r & mr) | (f & mf) | (h & mh) | (l & ml);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(idx*4); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_addr(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd(int idx, output logic [31:0] d);
    rd_addr(AW'(idx*4), d);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic clear_flags();
    wr(I_RF, ONES); wr(I_FF, ONES); wr(I_HF, ONES); wr(I_LF, ONES);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog run did not complete");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, a, m, p, q, mr, mf, mh, ml, er, ef, eh, el;
    logic [31:0] gr, gf, gh, gl;
    int seed_init;
    int storage_idx [12] = '{I_SENSE, I_DRVEN, I_DRVVAL, I_PULL, I_STR, I_RM,
                             I_FM, I_HM, I_LM, I_AEN, I_ASEL, I_POL};
    seed_init = $urandom(32'h0C0FFEE);
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = ONES;

    // R1 reset state
    repeat (2) @(posedge clk);
    for (int r = 0; r < 17; r++) begin
      rd(r, d);
      check("R1 reg", d, 32'h0);
    end
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pullup", pad_pullup, 32'h0);
    check("R1 alt", alt_en | alt_sel | pad_strength, 32'h0);
    check("R1 irq", irq, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int r = 0; r < 17; r++) model[r] = 32'h0;

    // base condition: pad low, all sensing
    pad_in = '0;
    wr(I_SENSE, ONES); model[I_SENSE] = ONES;
    settle();
    clear_flags();
    rd(I_RF, d); check("R6 rise cleared", d, 32'h0);
    rd(I_HF, d); check("R6 high cleared", d, 32'h0);
    rd(I_LF, d); check("R7 low re-set on clear", d, ONES);

    // R5 rising edge on pin 3 sets rise and high
    @(negedge clk); pad_in = 32'h8;
    settle();
    rd(I_RF, d); check("R5 rise", d, 32'h8);
    rd(I_HF, d); check("R5 high", d, 32'h8);
    rd(I_FF, d); check("R5 no fall", d, 32'h0);
    check("R8 R9 masked irq", irq, 32'h0);
    wr(I_RM, 32'h8);
    #1 check("R9 irq rise", irq, 32'h8);

    // R6 write-one clear, per bit, zero no effect
    wr(I_RF, 32'h0);  rd(I_RF, d); check("R6 zero keeps", d, 32'h8);
    wr(I_RF, 32'h20); rd(I_RF, d); check("R6 other bit keeps", d, 32'h8);
    wr(I_RF, 32'h8);  rd(I_RF, d); check("R6 bit clears", d, 32'h0);
    check("R9 irq gone", irq, 32'h0);
    wr(I_RM, 32'h0);

    // R7 level re-set vs. clear of a level not holding
    wr(I_HF, 32'h8); rd(I_HF, d); check("R7 high re-set", d, 32'h8);
    wr(I_LF, 32'h8); rd(I_LF, d); check("R7 low clears", d, 32'hFFFF_FFF7);

    // falling edge
    @(negedge clk); pad_in = 32'h0;
    settle();
    rd(I_FF, d); check("R5 fall", d, 32'h8);
    rd(I_LF, d); check("R5 low", d, ONES);

    // R10 disabling sense while pad high
    @(negedge clk); pad_in = ONES;
    settle();
    clear_flags();
    rd(I_LF, d); check("R10 low clear while high", d, 32'h0);
    wr(I_SENSE, 32'h0);
    settle();
    rd(I_IN, d); check("R10 disabled reads low", d, 32'h0);
    rd(I_LF, d); check("R10 low set", d, ONES);
    rd(I_FF, d); check("R10 fall set", d, ONES);

    // R4 synchronizer latency and gating
    @(negedge clk); pad_in = '0;
    wr(I_SENSE, ONES);
    settle();
    a = $urandom() | 32'h1;
    @(negedge clk);
    pad_in = a; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = '0;
    @(posedge clk); @(negedge clk); #1 check("R4 one edge old", bus_rdata, 32'h0);
    @(posedge clk); @(negedge clk); #1 check("R4 two edges new", bus_rdata, a);
    bus_sel = 1'b0;
    m = $urandom();
    wr(I_SENSE, m);
    settle();
    rd(I_IN, d); check("R4 gated", d, a & m);
    wr(I_IN, ~a);
    rd(I_IN, d); check("R2 input read-only", d, a & m);
    rd_addr(7'h44, d); check("R2 unmapped 0x44", d, 32'h0);
    rd_addr(7'h7C, d); check("R2 unmapped 0x7C", d, 32'h0);
    wr(I_SENSE, ONES);

    // R2/R3 random readback and pad mirroring
    for (int k = 0; k < 24; k++) begin
      int idx = storage_idx[$urandom() % 12];
      d = $urandom();
      wr(idx, d); model[idx] = d;
      rd(idx, d); check("R2 readback", d, model[idx]);
      check("R3 pad_out", pad_out, model[I_DRVVAL] ^ model[I_POL]);
      check("R3 pad_oe", pad_oe, model[I_DRVEN]);
      check("R3 pullup", pad_pullup, model[I_PULL]);
      check("R3 strength", pad_strength, model[I_STR]);
      check("R3 alt", {alt_en ^ alt_sel}, model[I_AEN] ^ model[I_ASEL]);
    end

    // R3 preset before enabling driver
    wr(I_DRVEN, 32'h0);
    d = $urandom();
    wr(I_DRVVAL, d);
    check("R3 preset oe off", pad_oe, 32'h0);
    check("R3 preset value", pad_out, d ^ model[I_POL]);
    wr(I_DRVEN, ONES);
    check("R3 enable keeps value", pad_out, d ^ model[I_POL]);

    // R5 R7 R8 R9 random patterns with clears between them
    mr = $urandom(); mf = $urandom(); mh = $urandom(); ml = $urandom();
    wr(I_RM, mr); wr(I_FM, mf); wr(I_HM, mh); wr(I_LM, ml);
    m = $urandom() | 32'h1;
    wr(I_SENSE, m);
    settle();
    p = pad_in;
    for (int k = 0; k < 12; k++) begin
      clear_flags();
      q = $urandom();
      @(negedge clk); pad_in = q;
      repeat (3) @(posedge clk);
      er = (q & m) & ~(p & m);
      ef = (p & m) & ~(q & m);
      eh = (p & m) | (q & m);
      el = ~(p & m) | ~(q & m);
      rd(I_RF, gr); check("R5 rand rise", gr, er);
      rd(I_FF, gf); check("R5 rand fall", gf, ef);
      rd(I_HF, gh); check("R7 rand high", gh, eh);
      rd(I_LF, gl); check("R8 rand low", gl, el);
      check("R9 rand irq", irq, exp_irq(er, ef, eh, el, mr, mf, mh, ml));
      p = q;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule